// File: doc/BRIEF.md
# Video Memory Fill Engine

This block writes one byte value into a run of locations of a byte-wide 64 KiB video memory. A 16-bit data port feeds it. When fill mode is enabled and the engine is idle, a write to the data port starts an operation. The engine first stores that word as an ordinary write: the high byte goes to the current address and the low byte to the current address with bit 0 inverted. It then advances the address by the auto-increment value and begins filling at once. No further command is needed.

The fill byte is the low byte of the triggering word. It is captured once, at the trigger, and held until the operation ends. Each byte write, whether part of the trigger or of the fill, goes out only in a cycle where the memory access slot is granted. In any other cycle the engine stalls. The start address, the increment and the length come from register-side inputs, which are sampled at the trigger.

Top module: `vram_fill_engine`

## Requirements
- R1: A data-port write (`port_wr` high) with `fill_en` high while `busy` is low starts an operation, and `busy` is high from the next cycle on.
- R2: The first byte write of an operation puts bits 15:8 of the triggering word at the sampled start address.
- R3: The second byte write puts bits 7:0 of the triggering word at the start address with bit 0 inverted.
- R4: The first fill write goes to the start address plus the sampled increment. Each later fill write goes to the previous fill address plus the increment, taken modulo 65536.
- R5: Every fill write carries bits 7:0 of the triggering word.
- R6: An operation with length N makes exactly N fill writes, so N+2 byte writes in total.
- R7: `mem_we` is high only in cycles where `mem_grant` is high. While the grant is low, `mem_addr` and `mem_data` hold their values and no write is lost.
- R8: `busy` stays high until the cycle in which the last byte write is made, and is low from the next cycle on.
- R9: While `busy` is high, data-port writes and changes on the configuration inputs have no effect. A data-port write with `fill_en` low starts nothing.
- R10: With length 0, only the two triggering byte writes are made.
- R11: With increment 1, an even start address gets its odd partner written twice (by the trigger and then by the first fill write). An odd start address gets no location written twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Fill mode armed |
| cfg_addr | input | 16 | Start address |
| cfg_inc | input | 8 | Auto-increment step |
| cfg_len | input | 16 | Number of fill bytes |
| port_wr | input | 1 | Data-port write strobe |
| port_data | input | 16 | Data-port write word |
| mem_grant | input | 1 | Memory access slot available this cycle |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 16 | Byte write address |
| mem_data | output | 8 | Byte write data |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check every cycle that a trigger raises `busy` with the start address on the bus, and that the second trigger write lands on the parity partner of the first. They also check that consecutive fill addresses differ by the increment, that a stall freezes the write bus, and that `busy` only falls right after a write. The bench's scenarios show the rest. These are the exact write count per length, the fill byte taken from the low half of the word, wrap-around past 0xFFFF, the double write on even start addresses, and that writes and configuration changes during an operation are ignored. The bench drives the grant both steadily and from a pseudo-random pattern.

// File: rtl/vram_fill_engine.sv
module vram_fill_engine #(
  parameter int AW = 16,
  parameter int IW = 8,
  parameter int LW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [AW-1:0] cfg_addr,
  input  logic [IW-1:0] cfg_inc,
  input  logic [LW-1:0] cfg_len,
  input  logic          port_wr,
  input  logic [DW-1:0] port_data,
  input  logic          mem_grant,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW/2-1:0] mem_data,
  output logic          busy
);
  localparam int BW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_FILL} st_t;

  st_t           st;
  logic [AW-1:0] cur;
  logic [IW-1:0] inc_q;
  logic [LW-1:0] left;
  logic [DW-1:0] word_q;

  wire start = port_wr && fill_en && (st == S_IDLE);
  wire [AW-1:0] nxt = cur + AW'(inc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= '0;
      inc_q  <= '0;
      left   <= '0;
      word_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur    <= cfg_addr;
          inc_q  <= cfg_inc;
          left   <= cfg_len;
          word_q <= port_data;
          st     <= S_HI;
        end
        S_HI: if (mem_grant) st <= S_LO;
        S_LO: if (mem_grant) begin
          cur <= nxt;
          st  <= (left == '0) ? S_IDLE : S_FILL;
        end
        S_FILL: if (mem_grant) begin
          cur  <= nxt;
          left <= left - LW'(1);
          if (left == LW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mem_we   = busy && mem_grant;
  assign mem_addr = (st == S_LO) ? (cur ^ AW'(1)) : cur;
  assign mem_data = (st == S_HI) ? word_q[DW-1:BW] : word_q[BW-1:0];

  // R1
  trigger_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && fill_en && !busy) |=> (busy && mem_addr == $past(cfg_addr)));

  // R3
  pair_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && mem_grant) |=> (mem_addr == ($past(mem_addr) ^ AW'(1))));

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_grant) |=> (!busy || mem_addr == AW'($past(mem_addr) + AW'($past(inc_q)))));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_grant) |=> (busy && $stable(mem_addr) && $stable(mem_data)));

  // R8
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we));
endmodule

// File: tb/sim_vram_fill_engine.sv
module sim_vram_fill_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        fill_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_inc = '0;
  logic [15:0] cfg_len = '0;
  logic        port_wr = 1'b0;
  logic [15:0] port_data = '0;
  logic        mem_grant = 1'b1;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        busy;

  vram_fill_engine u0 (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .cfg_addr(cfg_addr),
    .cfg_inc(cfg_inc), .cfg_len(cfg_len), .port_wr(port_wr),
    .port_data(port_data), .mem_grant(mem_grant), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] qa[$];
  logic [7:0]  qd[$];
  int          qt[$];
  bit          mbusy = 0;
  int          wcnt[int];
  int          nwr = 0;
  bit          gmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string addr_tag(input int t);
    if (t == 2) return "R2 high byte address";
    if (t == 3) return "R3 low byte address";
    return "R4 fill address";
  endfunction

  function automatic string data_tag(input int t);
    if (t == 2) return "R2 high byte data";
    if (t == 3) return "R3 low byte data";
    return "R5 fill byte data";
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_grant = gmode ? lfsr[0] : 1'b1;
  end

  // reference model: advances on each edge from the inputs it saw
  always @(posedge clk) begin
    bit was;
    logic [15:0] a;
    if (!rst_n) begin
      mbusy = 0;
      qa.delete(); qd.delete(); qt.delete();
    end else begin
      was = mbusy;
      if (mbusy && mem_grant && qa.size() > 0) begin
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
        if (qa.size() == 0) mbusy = 0;
      end
      if (port_wr && fill_en && !was) begin
        a = cfg_addr;
        qa.push_back(a);        qd.push_back(port_data[15:8]); qt.push_back(2);
        qa.push_back(a ^ 16'h1); qd.push_back(port_data[7:0]); qt.push_back(3);
        a = a + 16'(cfg_inc);
        for (int i = 0; i < int'(cfg_len); i++) begin
          qa.push_back(a); qd.push_back(port_data[7:0]); qt.push_back(4);
          a = a + 16'(cfg_inc);
        end
        mbusy = 1;
      end
    end
  end

  // per-cycle comparison, away from the edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit exp_we;
      chk(busy == mbusy, "R1/R8 busy", busy, mbusy);
      exp_we = mbusy && mem_grant;
      chk(mem_we == exp_we, "R7 write strobe", mem_we, exp_we);
      if (mem_we && exp_we && qa.size() > 0) begin
        chk(mem_addr == qa[0], addr_tag(qt[0]), mem_addr, qa[0]);
        chk(mem_data == qd[0], data_tag(qt[0]), mem_data, qd[0]);
      end
      if (mem_we) begin
        nwr++;
        if (wcnt.exists(int'(mem_addr))) wcnt[int'(mem_addr)]++;
        else wcnt[int'(mem_addr)] = 1;
      end
    end
  end

  task automatic trigger(input logic [15:0] a, input logic [7:0] inc,
                         input logic [15:0] len, input logic [15:0] w);
    @(negedge clk);
    cfg_addr = a; cfg_inc = inc; cfg_len = len; port_data = w;
    fill_en = 1'b1; port_wr = 1'b1;
    @(negedge clk);
    port_wr = 1'b0;
  endtask

  task automatic finish_op();
    while (busy) @(negedge clk);
    @(negedge clk);
    #3;
  endtask

  task automatic run_fill(input logic [15:0] a, input logic [7:0] inc,
                          input logic [15:0] len, input logic [15:0] w);
    nwr = 0; wcnt.delete();
    trigger(a, inc, len, w);
    finish_op();
    chk(nwr == int'(len) + 2, "R6 total byte writes", nwr, int'(len) + 2);
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(busy == 1'b0, "R8 reset idle busy", busy, 0);
    chk(mem_we == 1'b0, "R7 reset no write", mem_we, 0);

    // R11 odd start, step 1
    run_fill(16'h0001, 8'd1, 16'd4, 16'hA55A);
    foreach (wcnt[k]) chk(wcnt[k] == 1, "R11 odd start single writes", wcnt[k], 1);

    // R11 even start, step 1
    run_fill(16'h0010, 8'd1, 16'd3, 16'h1234);
    chk(wcnt.exists(32'h11) && wcnt[32'h11] == 2, "R11 even start odd partner twice",
        wcnt.exists(32'h11) ? wcnt[32'h11] : 0, 2);

    // R10 zero length
    run_fill(16'h0200, 8'd2, 16'd0, 16'hBEEF);
    chk(nwr == 2, "R10 zero length writes", nwr, 2);

    // R4 wrap past top of memory
    run_fill(16'hFFFC, 8'd2, 16'd4, 16'h7E81);
    chk(wcnt.exists(32'h0000) && wcnt.exists(32'h0002), "R4 wrap to low addresses", 0, 1);

    // R7 random grant stalls
    gmode = 1;
    run_fill(16'h1234, 8'h20, 16'd6, 16'hC35A);
    run_fill(16'h4001, 8'h81, 16'd9, 16'h0FF0);

    // R9 writes and config changes during an operation
    nwr = 0;
    trigger(16'h3000, 8'd3, 16'd8, 16'h5AA5);
    repeat (3) begin
      @(negedge clk);
      cfg_addr = 16'h9999; cfg_inc = 8'd7; cfg_len = 16'd1;
      port_data = 16'hFFFF; port_wr = 1'b1;
      @(negedge clk);
      port_wr = 1'b0;
    end
    finish_op();
    chk(nwr == 10, "R9 ignored writes while busy", nwr, 10);
    gmode = 0;

    // R9 disarmed write starts nothing
    nwr = 0;
    @(negedge clk);
    fill_en = 1'b0; port_wr = 1'b1; port_data = 16'h4242; cfg_len = 16'd2;
    @(negedge clk);
    port_wr = 1'b0;
    #3;
    chk(busy == 1'b0, "R9 disarmed write busy", busy, 0);
    repeat (3) @(negedge clk);
    #3;
    chk(nwr == 0, "R9 disarmed write count", nwr, 0);

    // R1 back-to-back operations
    run_fill(16'h8000, 8'd1, 16'd2, 16'h0102);
    run_fill(16'h8003, 8'd4, 16'd5, 16'h0304);

    summary();
  end
endmodule